// File: doc/BRIEF.md
# Constant Ratio Sample Scaler

This block multiplies a stream of 9-bit signed two's complement samples by the fixed gain 17/sqrt(21), which is about 3.7097. The gain is irrational, so the block approximates it as an integer multiplier M over a power-of-two divisor 2^K. The divide is therefore only an arithmetic right shift. A precision index chosen at elaboration picks the (M, K) pair. A higher index gives a more exact gain but needs a wider multiplier constant.

Samples arrive with a valid strobe, and there is no back-pressure. Every valid sample yields one result exactly one clock later, with a matching valid strobe, so the block accepts a new sample on every clock. The scaled value is rounded to the nearest integer, with halves rounded away from zero. It is then clamped to the signed output width. Once the scaling is done, extra gain precision is useless if the output width cannot resolve it. For that reason the block lowers the index until the shift K fits the output width.

Top module: `ratio_scaler`

## Requirements
- R1: The index PREC picks (M, K) from this table: 0 → 59/2^4, 1 → 119/2^5, 2 → 237/2^6, 3 → 475/2^7, 4 → 1899/2^9, 5 → 3799/2^10, 6 → 7597/2^11, 7 → 15195/2^12. The result is round(x·M / 2^K).
- R2: `outValid` is high in the cycle after the clock edge that sampled `inValid` high, and low after an edge that sampled it low. Each valid input produces exactly one result.
- R3: When x·M/2^K lies exactly halfway between two integers, the result is the integer of larger magnitude. For example, with 59/2^4 an input of 8 gives 30 and an input of -8 gives -30.
- R4: A result above 2^(OUT_W-1)-1 is replaced by that value. A result below -2^(OUT_W-1) is replaced by that value. With OUT_W=10 and index 0, input 255 gives 511 and input -256 gives -512.
- R5: While `inValid` is low, `outResult` keeps its last value, and the sample on `inSample` is ignored.
- R6: The effective index is PREC, lowered step by step while its K exceeds OUT_W-1. With OUT_W=11 and PREC=7, the block uses 3799/2^10.
- R7: During reset `outValid` is 0 and `outResult` is 0.
- R8: An input of 0 gives 0. An input and its negation give results of equal magnitude and opposite sign, unless the result is clamped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe |
| inSample | input | 9 | Signed input sample |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outResult | output | OUT_W | Signed, rounded and saturated result |

## Verification
The hardest cases to reach are exact rounding ties and saturation. At the widest precision the multiplier is odd and the shift is 12, so no 9-bit input lands on a half. With an 11-bit or wider output the scaled range never overflows. The bench therefore runs two more instances next to the default one. One has a 10-bit output with the 59/16 pair, where inputs of ±8 land exactly on halves and the input extremes clamp. The other has an 11-bit output that asks for the finest pair and must fall back to 3799/1024. All three share one stimulus stream. Idle gaps in that stream carry changing sample values, to show the idle samples are ignored.

// File: rtl/ratio_scaler_pkg.sv
package ratio_scaler_pkg;

  localparam int NUM_PREC = 8;

  // multiplier constant for each precision index
  function automatic int precMult(input int idx);
    case (idx)
      0: return 59;
      1: return 119;
      2: return 237;
      3: return 475;
      4: return 1899;
      5: return 3799;
      6: return 7597;
      default: return 15195;
    endcase
  endfunction

  // power-of-two exponent for each precision index
  function automatic int precShift(input int idx);
    case (idx)
      0: return 4;
      1: return 5;
      2: return 6;
      3: return 7;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction

  // lower the index until the shift is no finer than the output resolves
  function automatic int clampPrec(input int prec, input int outW);
    int idx;
    idx = prec;
    if (idx > NUM_PREC - 1) idx = NUM_PREC - 1;
    if (idx < 0) idx = 0;
    while (idx > 0 && precShift(idx) > outW - 1) idx = idx - 1;
    return idx;
  endfunction

  typedef struct packed {
    logic capture;  // load the datapath result register
  } scaleCtrl_t;

endpackage

// File: rtl/ratio_scaler_ctl.sv
module ratio_scaler_ctl
  import ratio_scaler_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output scaleCtrl_t ctrl,
  output logic       outValid
);

  always_comb begin
    ctrl.capture = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/ratio_scaler_dp.sv
module ratio_scaler_dp
  import ratio_scaler_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16,
  parameter int MULT  = 15195,
  parameter int SHIFT = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  scaleCtrl_t              ctrl,
  input  logic signed [IN_W-1:0]  inSample,
  output logic signed [OUT_W-1:0] outResult
);

  localparam int MUL_W  = 17;
  localparam int PROD_W = IN_W + MUL_W;
  localparam logic signed [MUL_W-1:0] MULT_S  = MUL_W'(MULT);
  localparam logic [PROD_W-1:0]       HALF    = PROD_W'(1) << (SHIFT - 1);
  localparam logic [PROD_W-1:0]       POS_LIM = (PROD_W'(1) << (OUT_W - 1)) - PROD_W'(1);
  localparam logic [PROD_W-1:0]       NEG_LIM = PROD_W'(1) << (OUT_W - 1);
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] product;
  logic                     isNeg;
  logic [PROD_W-1:0]        magnitude;
  logic [PROD_W-1:0]        roundedMag;
  logic signed [OUT_W-1:0]  nextResult;

  always_comb begin
    product    = PROD_W'(inSample) * PROD_W'(MULT_S);
    isNeg      = product[PROD_W-1];
    magnitude  = isNeg ? PROD_W'(-product) : PROD_W'(product);
    roundedMag = (magnitude + HALF) >> SHIFT;
    if (!isNeg && roundedMag > POS_LIM)
      nextResult = OUT_MAX;
    else if (isNeg && roundedMag > NEG_LIM)
      nextResult = OUT_MIN;
    else if (isNeg)
      nextResult = -$signed(roundedMag[OUT_W-1:0]);
    else
      nextResult = $signed(roundedMag[OUT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outResult <= '0;
    else if (ctrl.capture) outResult <= nextResult;
  end

endmodule

// File: rtl/ratio_scaler.sv
module ratio_scaler
  import ratio_scaler_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16,
  parameter int PREC  = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inSample,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outResult
);

  localparam int EFF_PREC = clampPrec(PREC, OUT_W);
  localparam int MULT     = precMult(EFF_PREC);
  localparam int SHIFT    = precShift(EFF_PREC);

  scaleCtrl_t ctrl;

  ratio_scaler_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  ratio_scaler_dp #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .MULT  (MULT),
    .SHIFT (SHIFT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .inSample  (inSample),
    .outResult (outResult)
  );

endmodule

// File: rtl/ratio_scaler_chk.sv
module ratio_scaler_chk #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic signed [IN_W-1:0]  inSample,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] outResult
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outResult));

  a_r8_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSample == '0) |=> outResult == '0);

  a_r8_sign: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inSample[IN_W-1]) |=> !outResult[OUT_W-1]);

  a_r8_neg_sign: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSample[IN_W-1]) |=> outResult[OUT_W-1]);

endmodule

bind ratio_scaler ratio_scaler_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inSample  (inSample),
  .outValid  (outValid),
  .outResult (outResult)
);

// File: tb/ratio_scaler_test.sv
module ratio_scaler_test;

  typedef struct {
    longint value;
    string  tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [8:0] inSample = '0;

  logic               vWide, vMid, vNarrow;
  logic signed [15:0] rWide;
  logic signed [10:0] rMid;
  logic signed [9:0]  rNarrow;

  int checks = 0;
  int bad = 0;
  bit running = 1'b1;

  expItem_t qWide[$];
  expItem_t qMid[$];
  expItem_t qNarrow[$];
  longint lastWide = 0, lastMid = 0, lastNarrow = 0;

  always #2 clk = ~clk;

  // default: OUT_W=16, index 7 -> 15195/2^12
  ratio_scaler uut (.clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
                    .outValid(vWide), .outResult(rWide));
  // R6: index 7 requested, 11-bit output limits it to 3799/2^10
  ratio_scaler #(.OUT_W(11), .PREC(7)) uMid (.clk(clk), .rstN(rstN), .inValid(inValid),
                    .inSample(inSample), .outValid(vMid), .outResult(rMid));
  // 10-bit output, 59/2^4: exact halves and clamping reachable
  ratio_scaler #(.OUT_W(10), .PREC(0)) uNarrow (.clk(clk), .rstN(rstN), .inValid(inValid),
                    .inSample(inSample), .outValid(vNarrow), .outResult(rNarrow));

  function automatic longint refScale(input longint x, input longint m, input int k, input int w);
    longint p, h, r, hi, lo;
    p = x * m;
    h = longint'(1) << (k - 1);
    if (p >= 0) r = (p + h) / (longint'(1) << k);
    else        r = -((-p + h) / (longint'(1) << k));
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp, input string what);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic send(input int x, input string tag);
    @(negedge clk);
    inValid  = 1'b1;
    inSample = 9'(x);
    qWide.push_back('{refScale(x, 15195, 12, 16), tag});
    qMid.push_back('{refScale(x, 3799, 10, 11), {tag, " R6"}});
    qNarrow.push_back('{refScale(x, 59, 4, 10), tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid  = 1'b0;
      inSample = 9'(i * 97 + 13);  // R5: changing sample while idle
    end
  endtask

  task automatic monitorOne(input string name, input logic v, input longint got,
                            ref expItem_t q[$], ref longint last);
    expItem_t it;
    if (v) begin
      if (q.size() == 0) begin
        check("R2", 1, 0, {name, " unexpected outValid"});
      end else begin
        it = q.pop_front();
        check(it.tag, got, it.value, {name, " result"});
        last = got;
      end
    end else begin
      check("R5", got, last, {name, " hold while idle"});
    end
  endtask

  always @(negedge clk) begin
    if (rstN && running) begin
      monitorOne("wide", vWide, longint'(rWide), qWide, lastWide);
      monitorOne("mid", vMid, longint'(rMid), qMid, lastMid);
      monitorOne("narrow", vNarrow, longint'(rNarrow), qNarrow, lastNarrow);
    end
  end

  initial begin
    #(200000 * 4);
    check("watchdog", 1, 0, "run timed out");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", longint'(vWide), 0, "outValid in reset");
    check("R7", longint'(rWide), 0, "outResult in reset");
    check("R7", longint'(vNarrow), 0, "narrow outValid in reset");
    check("R7", longint'(rNarrow), 0, "narrow outResult in reset");
    rstN = 1'b1;
    idle(2);

    send(0, "R8");
    send(1, "R1");
    send(-1, "R8");
    send(8, "R3");
    send(-8, "R3");
    idle(3);
    send(255, "R4");
    send(-256, "R4");
    send(100, "R1");
    send(-100, "R8");
    idle(1);
    send(37, "R1");
    idle(2);
    // R2: back-to-back stream over the input range
    for (int x = -256; x < 256; x += 23) send(x, "R2");
    idle(4);
    send(-255, "R1");
    send(254, "R4");
    idle(3);

    check("R2", qWide.size() + qMid.size() + qNarrow.size(), 0, "results left pending");
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule